// File: doc/BRIEF.md
# Cascaded Serial Word Transmitter

This block is the host-side sender for a chain of serial devices that each hold a 7-bit code. The devices are wired so that one device's data output feeds the next device's data input. The host supplies one code per device as a single flat vector and pulses a start input. The block then produces one chip-select-low window and sends every bit of every code in it. When the window closes, each device in the chain holds its own code.

The serial clock is derived from the system clock through a programmable half-period divider. This lets a long chain, with slow pull-up edges between stages, be driven at a lower rate. The divider value and the codes are captured when a frame is accepted. A busy level covers the whole frame, and a single-cycle done pulse marks its end.

Top module: `chain_frame_tx`

## Requirements
- R1: A frame contains exactly 7·N_DEV rising serial-clock edges, all inside one chip-select-low window.
- R2: Field `codes_i[7k +: 7]` is the code for device k, where device 0 is nearest the host. The field for device N_DEV-1 is sent first. The whole vector goes out from bit 7·N_DEV-1 down to bit 0, so each code is sent MSB first. After the frame, every device holds its own field.
- R3: `cs_no` stays low from frame start until after the last rising edge, and rises once. The serial clock toggles only while `cs_no` is low.
- R4: `sdo_o` changes only together with a falling serial-clock edge, or at frame start. It never changes while `sclk_o` is high.
- R5: Each serial-clock half period lasts `div_i`+1 system clocks, so `cs_no` is low for exactly (2·7·N_DEV+1)·(`div_i`+1) cycles.
- R6: The first rising edge comes `div_i`+1 cycles after `cs_no` falls. `cs_no` rises `div_i`+1 cycles after the last falling edge.
- R7: A start pulse while `busy_o` is high has no effect on the frame in progress, and no second frame follows it.
- R8: `div_i` and `codes_i` are captured at the accepted start. Later changes do not alter the frame's timing or data.
- R9: `done_o` is high for exactly one cycle: the first cycle in which `cs_no` is high again.
- R10: After reset, `cs_no` is 1, and `sclk_o`, `sdo_o`, `busy_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request, accepted when idle |
| div_i | input | DIV_W | Half-period length minus one, in system clocks |
| codes_i | input | 7·N_DEV | Codes, device k at bits [7k +: 7] |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data to first device |

## Verification
A behavioural model of the device chain sits on the serial pins. It shifts on rising edges and commits on the rising chip select. If the shift register or bit counter is off by one, a device's code is rotated or misplaced. The frame length also changes, and this is visible as soon as chip select rises. A divider fault shows as wrong setup and window lengths within the first frame. A start leaking through while busy shows as a stretched window, or as a second window opening right after done.

// File: rtl/chain_tx_pkg.sv
package chain_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_HOLD = 2'd3
  } tx_state_e;
endpackage

// File: rtl/chain_tx_divider.sv
module chain_tx_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q, cnt_q;

  assign tick_o = run_i && (cnt_q == div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      div_q <= div_i;
      cnt_q <= '0;
    end else if (!run_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= div_q); // R5
endmodule

// File: rtl/chain_tx_shifter.sv
module chain_tx_shifter #(
  parameter int TOT = 14
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           shift_i,
  input  logic [TOT-1:0] data_i,
  output logic           bit_o,
  output logic           last_o
);
  localparam int CW = $clog2(TOT);
  localparam logic [CW-1:0] LAST = CW'(TOT - 1);

  logic [TOT-1:0] sreg_q;
  logic [CW-1:0]  cnt_q;

  assign bit_o  = sreg_q[TOT-1];
  assign last_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      sreg_q <= data_i;
      cnt_q  <= '0;
    end else if (shift_i) begin
      sreg_q <= {sreg_q[TOT-2:0], 1'b0};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_BITCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R1
  AST_NO_SHIFT_PAST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |-> !last_o); // R1
endmodule

// File: rtl/chain_frame_tx.sv
module chain_frame_tx
  import chain_tx_pkg::*;
#(
  parameter int N_DEV  = 2,
  parameter int WORD_W = 7,
  parameter int DIV_W  = 8,
  localparam int TOT   = N_DEV * WORD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [TOT-1:0]   codes_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             sdo_o
);
  tx_state_e state_q;
  logic      cs_n_q, sclk_q, done_q;
  logic      tick, last, accept, shift;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign shift  = (state_q == ST_HI) && tick && !last;

  chain_tx_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .run_i (state_q != ST_IDLE),
    .div_i (div_i),
    .tick_o(tick)
  );

  chain_tx_shifter #(.TOT(TOT)) u_shf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .shift_i(shift),
    .data_i (codes_i),
    .bit_o  (sdo_o),
    .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LO;
          cs_n_q  <= 1'b0;
        end
        ST_LO: if (tick) begin
          state_q <= ST_HI;
          sclk_q  <= 1'b1;
        end
        ST_HI: if (tick) begin
          sclk_q  <= 1'b0;
          state_q <= last ? ST_HOLD : ST_LO;
        end
        ST_HOLD: if (tick) begin
          state_q <= ST_IDLE;
          cs_n_q  <= 1'b1;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign cs_no  = cs_n_q;
  assign sclk_o = sclk_q;
  assign done_o = done_q;

  AST_SDO_STABLE_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdo_o)); // R4
  AST_SCLK_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_AT_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && $past(!cs_no))); // R9
  AST_BUSY_MATCHES_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cs_no); // R3
endmodule

// File: tb/sim_chain_frame_tx.sv
module sim_chain_frame_tx;
  localparam int N_DEV = 2;
  localparam int WW    = 7;
  localparam int DIV_W = 8;
  localparam int TOT   = N_DEV * WW;
  localparam int NV    = 4;

  localparam logic [DIV_W+TOT-1:0] VEC [NV] = '{
    {8'd0, 7'h55, 7'h2A},
    {8'd1, 7'h7F, 7'h00},
    {8'd3, 7'h40, 7'h01},
    {8'd2, 7'h12, 7'h6D}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic [TOT-1:0]   codes = '0;
  logic busy, done, cs_n, sclk, sdo;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  chain_frame_tx #(.N_DEV(N_DEV), .WORD_W(WW), .DIV_W(DIV_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .div_i(div), .codes_i(codes),
    .busy_o(busy), .done_o(done), .cs_no(cs_n), .sclk_o(sclk), .sdo_o(sdo)
  );

  // device chain model: shift on rising sclk, commit on rising cs
  logic [WW-1:0] dev_sr [N_DEV];
  logic [WW-1:0] dev_lat[N_DEV];
  always @(posedge sclk) if (!cs_n) begin
    dev_sr[0] <= {dev_sr[0][WW-2:0], sdo};
    for (int k = 1; k < N_DEV; k++) dev_sr[k] <= {dev_sr[k][WW-2:0], dev_sr[k-1][WW-1]};
  end
  always @(posedge cs_n) for (int k = 0; k < N_DEV; k++) dev_lat[k] <= dev_sr[k];

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [DIV_W-1:0] d, input logic [TOT-1:0] c, input bit inject);
    int low = 0, setup = 0, rises = 0, tail = 0;
    bit seen_hi = 0, prev = 0;
    @(negedge clk);
    div = d; codes = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!cs_n) begin
      low++;
      if (sclk && !prev) begin rises++; seen_hi = 1; end
      if (!seen_hi) setup++;
      if (!sclk) tail++; else tail = 0;
      if (inject && low == 3) begin
        start = 1'b1; div = d + 8'd2; codes = ~c;
      end
      if (inject && low == 5) start = 1'b0;
      if (low > 100000) break;
      prev = sclk;
      @(negedge clk);
    end
    chk("R1 rising edges", rises, TOT);
    chk("R5 window length", low, (2*TOT+1)*(int'(d)+1));
    chk("R6 setup cycles", setup, int'(d)+1);
    chk("R6 hold cycles", tail, int'(d)+1);
    chk("R9 done at cs rise", done, 1);
    for (int k = 0; k < N_DEV; k++)
      chk($sformatf("R2 device %0d code", k), dev_lat[k], c[k*WW +: WW]);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
    div = d; codes = c; start = 1'b0;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 cs idle", cs_n, 1);
    chk("R10 sclk idle", sclk, 0);
    chk("R10 sdo idle", sdo, 0);
    chk("R10 busy idle", busy, 0);
    chk("R10 done idle", done, 0);

    for (int i = 0; i < NV; i++)
      run_frame(VEC[i][DIV_W+TOT-1:TOT], VEC[i][TOT-1:0], 1'b0);

    // R7 R8: start and new inputs mid-frame are ignored
    run_frame(8'd1, {7'h33, 7'h4C}, 1'b1);
    begin
      int stray = 0;
      for (int j = 0; j < 20; j++) begin
        if (!cs_n || busy) stray++;
        @(negedge clk);
      end
      chk("R7 no second frame", stray, 0);
    end

    // R3 R1: back-to-back frames, largest divider used here
    run_frame(8'd5, {7'h01, 7'h7E}, 1'b0);
    run_frame(8'd0, {7'h00, 7'h7F}, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule